// File: doc/BRIEF.md
# Branch Redirect Arbiter

This block collects redirect requests from the execution pipes and the retirement logic of an out-of-order core, and produces two outputs. Five execution mispredict ports (one jump pipe, four ALU pipes) report a reorder-buffer age, a fetch-target-queue pointer and an instruction offset. The block picks the oldest of them and registers it. In the same cycle it drives the queue pointer out on a read port, so that the fetch PC comes back one cycle later.

In the second stage the execution candidate competes with a load-replay redirect, which already carries its own target. The winner leaves at once as the backend flush. This stage-2 result is registered into a third stage. There a redirect from the reorder buffer (exception, interrupt or flush) takes priority over it, and the result goes to the fetch frontend together with a flush-all pulse for unconditional redirects. Ages are compared as reorder-buffer pointers made of a wrap flag and an index. A is older than B when the flags match and A's index is smaller, or when the flags differ and A's index is larger.

Top module: `redirect_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it with no request inputs, `be_valid`, `fe_valid` and `fe_flush_all` are low.
- R2: Among the valid execution ports the oldest by the pointer rule wins, and the lowest port number wins a tie. `ftq_rd_ptr` carries the winner's queue pointer in the cycle its request is present.
- R3: A surviving execution candidate appears on the backend output one cycle after its request. Its level is 2'b00 and its target is `ftq_rd_pc + (offset << INST_SHIFT)`, where `ftq_rd_pc` is the value returned in that later cycle.
- R4: A surviving load replay appears on the backend output in the cycle it is presented, with level 2'b01 and its own target.
- R5: When both the execution candidate and the load replay survive in stage 2, the strictly older one wins. On equal age the load replay wins.
- R6: Without a reorder-buffer redirect, the frontend output in a cycle equals the backend output of the previous cycle (valid, age, level, target).
- R7: A valid reorder-buffer redirect appears on the frontend output in the same cycle with its own age, level and target, overriding everything else.
- R8: A valid reorder-buffer redirect forces `be_valid` low in that cycle. It also discards the execution candidate captured in that cycle and the stage-3 record, so neither appears in the next cycle.
- R9: In stage 2, any request whose age is equal to or younger than the previous cycle's backend redirect is dropped.
- R10: `fe_flush_all` is high exactly when `fe_valid` is high and `fe_level` is 2'b10 (flush-after) or 2'b11 (exception).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exu_valid | input | N_EXU | Mispredict valid per execution port (port 0 is the jump pipe) |
| exu_rob_flag | input | N_EXU | Age wrap flag per port |
| exu_rob_idx | input | N_EXU x IDX_W | Age index per port |
| exu_ftq_ptr | input | N_EXU x FTQ_W | Fetch-target-queue pointer per port |
| exu_ftq_off | input | N_EXU x OFF_W | Instruction offset within the fetch block per port |
| ld_valid | input | 1 | Load-replay redirect valid |
| ld_rob_flag | input | 1 | Load-replay age flag |
| ld_rob_idx | input | IDX_W | Load-replay age index |
| ld_target | input | PC_W | Load-replay target PC |
| rob_valid | input | 1 | Reorder-buffer redirect valid |
| rob_rob_flag | input | 1 | Reorder-buffer redirect age flag |
| rob_rob_idx | input | IDX_W | Reorder-buffer redirect age index |
| rob_level | input | 2 | Reorder-buffer redirect level |
| rob_target | input | PC_W | Reorder-buffer redirect target PC |
| ftq_rd_ptr | output | FTQ_W | Queue read pointer for the stage-1 winner |
| ftq_rd_pc | input | PC_W | Fetch PC returned one cycle after the pointer |
| be_valid | output | 1 | Backend flush valid |
| be_rob_flag | output | 1 | Backend flush age flag |
| be_rob_idx | output | IDX_W | Backend flush age index |
| be_level | output | 2 | Backend flush level |
| be_target | output | PC_W | Backend flush target PC |
| fe_valid | output | 1 | Frontend redirect valid |
| fe_rob_flag | output | 1 | Frontend redirect age flag |
| fe_rob_idx | output | IDX_W | Frontend redirect age index |
| fe_level | output | 2 | Frontend redirect level |
| fe_target | output | PC_W | Frontend redirect target PC |
| fe_flush_all | output | 1 | Unconditional-redirect pulse |

## Verification
A wrong stage-1 choice shows one cycle later as a wrong age or target on the backend output, and again one cycle after that on the frontend output. A stale or uncleared stage-1, stage-3 or last-redirect register shows within one or two cycles: a redirect appears that should have been dropped or cancelled, or a correct one is lost. The pointer rule is stressed by ages drawn in a sliding window that crosses the wrap point often, so an inverted flag comparison turns into a wrong winner within a few cycles.

// File: rtl/redirect_arbiter.sv
`timescale 1ns/1ps
module redirect_arbiter #(
  parameter int N_EXU      = 5,
  parameter int IDX_W      = 4,
  parameter int FTQ_W      = 4,
  parameter int OFF_W      = 3,
  parameter int PC_W       = 16,
  parameter int INST_SHIFT = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_EXU-1:0]            exu_valid,
  input  logic [N_EXU-1:0]            exu_rob_flag,
  input  logic [N_EXU-1:0][IDX_W-1:0] exu_rob_idx,
  input  logic [N_EXU-1:0][FTQ_W-1:0] exu_ftq_ptr,
  input  logic [N_EXU-1:0][OFF_W-1:0] exu_ftq_off,
  input  logic                        ld_valid,
  input  logic                        ld_rob_flag,
  input  logic [IDX_W-1:0]            ld_rob_idx,
  input  logic [PC_W-1:0]             ld_target,
  input  logic                        rob_valid,
  input  logic                        rob_rob_flag,
  input  logic [IDX_W-1:0]            rob_rob_idx,
  input  logic [1:0]                  rob_level,
  input  logic [PC_W-1:0]             rob_target,
  output logic [FTQ_W-1:0]            ftq_rd_ptr,
  input  logic [PC_W-1:0]             ftq_rd_pc,
  output logic                        be_valid,
  output logic                        be_rob_flag,
  output logic [IDX_W-1:0]            be_rob_idx,
  output logic [1:0]                  be_level,
  output logic [PC_W-1:0]             be_target,
  output logic                        fe_valid,
  output logic                        fe_rob_flag,
  output logic [IDX_W-1:0]            fe_rob_idx,
  output logic [1:0]                  fe_level,
  output logic [PC_W-1:0]             fe_target,
  output logic                        fe_flush_all
);
  localparam logic [1:0] LVL_EXU = 2'b00;
  localparam logic [1:0] LVL_LD  = 2'b01;

  function automatic logic older(input logic af, input logic [IDX_W-1:0] ai,
                                 input logic bf, input logic [IDX_W-1:0] bi);
    return (af == bf) ? (ai < bi) : (ai > bi);
  endfunction

  // stage 1: oldest execution mispredict
  logic             sel_v, sel_f;
  logic [IDX_W-1:0] sel_i;
  logic [FTQ_W-1:0] sel_p;
  logic [OFF_W-1:0] sel_o;

  always_comb begin
    sel_v = 1'b0;
    sel_f = 1'b0;
    sel_i = '0;
    sel_p = '0;
    sel_o = '0;
    for (int k = 0; k < N_EXU; k++) begin
      if (exu_valid[k] && (!sel_v || older(exu_rob_flag[k], exu_rob_idx[k], sel_f, sel_i))) begin
        sel_v = 1'b1;
        sel_f = exu_rob_flag[k];
        sel_i = exu_rob_idx[k];
        sel_p = exu_ftq_ptr[k];
        sel_o = exu_ftq_off[k];
      end
    end
  end

  assign ftq_rd_ptr = sel_p;

  logic             s1_v, s1_f;
  logic [IDX_W-1:0] s1_i;
  logic [OFF_W-1:0] s1_o;
  logic             lb_v, lb_f;
  logic [IDX_W-1:0] lb_i;
  logic             s3_v, s3_f;
  logic [IDX_W-1:0] s3_i;
  logic [1:0]       s3_l;
  logic [PC_W-1:0]  s3_t;

  // stage 2: merge with load replay, filter against last backend redirect
  logic            x_ok, l_ok, take_x;
  logic [PC_W-1:0] x_tgt;

  assign x_ok   = s1_v && !(lb_v && !older(s1_f, s1_i, lb_f, lb_i));
  assign l_ok   = ld_valid && !(lb_v && !older(ld_rob_flag, ld_rob_idx, lb_f, lb_i));
  assign take_x = x_ok && (!l_ok || older(s1_f, s1_i, ld_rob_flag, ld_rob_idx));
  assign x_tgt  = ftq_rd_pc + (PC_W'(s1_o) << INST_SHIFT);

  assign be_valid    = (x_ok || l_ok) && !rob_valid;
  assign be_rob_flag = take_x ? s1_f  : ld_rob_flag;
  assign be_rob_idx  = take_x ? s1_i  : ld_rob_idx;
  assign be_level    = take_x ? LVL_EXU : LVL_LD;
  assign be_target   = take_x ? x_tgt : ld_target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_f <= 1'b0; s1_i <= '0; s1_o <= '0;
      lb_v <= 1'b0; lb_f <= 1'b0; lb_i <= '0;
      s3_v <= 1'b0; s3_f <= 1'b0; s3_i <= '0; s3_l <= '0; s3_t <= '0;
    end else begin
      s1_v <= sel_v && !rob_valid;
      s1_f <= sel_f;
      s1_i <= sel_i;
      s1_o <= sel_o;
      lb_v <= be_valid;
      lb_f <= be_rob_flag;
      lb_i <= be_rob_idx;
      s3_v <= be_valid;
      s3_f <= be_rob_flag;
      s3_i <= be_rob_idx;
      s3_l <= be_level;
      s3_t <= be_target;
    end
  end

  // stage 3: reorder-buffer redirect has priority
  assign fe_valid     = rob_valid || s3_v;
  assign fe_rob_flag  = rob_valid ? rob_rob_flag : s3_f;
  assign fe_rob_idx   = rob_valid ? rob_rob_idx  : s3_i;
  assign fe_level     = rob_valid ? rob_level    : s3_l;
  assign fe_target    = rob_valid ? rob_target   : s3_t;
  assign fe_flush_all = fe_valid && fe_level[1];
endmodule

// File: rtl/redirect_arbiter_chk.sv
`timescale 1ns/1ps
module redirect_arbiter_chk #(
  parameter int IDX_W = 4,
  parameter int PC_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rob_valid,
  input logic             rob_rob_flag,
  input logic [IDX_W-1:0] rob_rob_idx,
  input logic [1:0]       rob_level,
  input logic             be_valid,
  input logic             be_rob_flag,
  input logic [IDX_W-1:0] be_rob_idx,
  input logic [PC_W-1:0]  be_target,
  input logic             fe_valid,
  input logic [IDX_W-1:0] fe_rob_idx,
  input logic [1:0]       fe_level,
  input logic [PC_W-1:0]  fe_target,
  input logic             fe_flush_all
);
  function automatic logic older(input logic af, input logic [IDX_W-1:0] ai,
                                 input logic bf, input logic [IDX_W-1:0] bi);
    return (af == bf) ? (ai < bi) : (ai > bi);
  endfunction

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  assert_rob_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rob_valid |-> fe_valid && fe_rob_idx == rob_rob_idx && fe_level == rob_level);

  assert_rob_blocks_be_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rob_valid |-> !be_valid);

  assert_rob_clears_s3_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rob_valid |=> !fe_valid || rob_valid);

  assert_fe_follows_be_R6: assert property (@(posedge clk) disable iff (!rst_n)
    be_valid && !rob_valid |=> fe_valid &&
      (rob_valid || (fe_rob_idx == $past(be_rob_idx) && fe_target == $past(be_target))));

  assert_be_gets_older_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(be_valid) && be_valid |->
      older(be_rob_flag, be_rob_idx, $past(be_rob_flag), $past(be_rob_idx)));

  assert_flush_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fe_flush_all |-> fe_valid);
endmodule

bind redirect_arbiter redirect_arbiter_chk #(.IDX_W(IDX_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/sim_redirect_arbiter.sv
`timescale 1ns/1ps
module sim_redirect_arbiter;
  localparam int N = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]      exu_valid = '0, exu_rob_flag = '0;
  logic [N-1:0][3:0] exu_rob_idx = '0, exu_ftq_ptr = '0;
  logic [N-1:0][2:0] exu_ftq_off = '0;
  logic ld_valid = 0, ld_rob_flag = 0, rob_valid = 0, rob_rob_flag = 0;
  logic [3:0]  ld_rob_idx = '0, rob_rob_idx = '0;
  logic [1:0]  rob_level = '0;
  logic [15:0] ld_target = '0, rob_target = '0, ftq_rd_pc;
  logic [3:0]  ftq_rd_ptr;
  logic be_valid, be_rob_flag, fe_valid, fe_rob_flag, fe_flush_all;
  logic [3:0]  be_rob_idx, fe_rob_idx;
  logic [1:0]  be_level, fe_level;
  logic [15:0] be_target, fe_target;

  redirect_arbiter u0 (.*);

  function automatic logic [15:0] pcf(input logic [3:0] p);
    return 16'h4000 + 16'(p) * 16'h0040;
  endfunction
  always @(posedge clk) ftq_rd_pc <= pcf(ftq_rd_ptr);

  function automatic logic older(input logic af, input logic [3:0] ai,
                                 input logic bf, input logic [3:0] bi);
    if (af == bf) return ai < bi;
    return ai > bi;
  endfunction

  int checks = 0, fails = 0;
  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // reference state
  logic m1v = 0, m1f = 0, mlv = 0, mlf = 0, m3v = 0, m3f = 0;
  logic [3:0] m1i = 0, m1p = 0, mli = 0, m3i = 0;
  logic [2:0] m1o = 0;
  logic [1:0] m3l = 0;
  logic [15:0] m3t = 0;

  task automatic cycle(input string tag);
    logic sv, sf, xok, lok, tx, bv, bf, fv;
    logic [3:0] si, sp, bi;
    logic [2:0] so;
    logic [1:0] bl;
    logic [15:0] bt;
    #2;
    sv = 0; sf = 0; si = 0; sp = 0; so = 0;
    for (int k = 0; k < N; k++)
      if (exu_valid[k] && (!sv || older(exu_rob_flag[k], exu_rob_idx[k], sf, si))) begin
        sv = 1; sf = exu_rob_flag[k]; si = exu_rob_idx[k]; sp = exu_ftq_ptr[k]; so = exu_ftq_off[k];
      end
    if (sv) chk({tag, " R2"}, "ftq_rd_ptr", 32'(ftq_rd_ptr), 32'(sp));
    xok = m1v && !(mlv && !older(m1f, m1i, mlf, mli));
    lok = ld_valid && !(mlv && !older(ld_rob_flag, ld_rob_idx, mlf, mli));
    tx  = xok && (!lok || older(m1f, m1i, ld_rob_flag, ld_rob_idx));
    bv  = (xok || lok) && !rob_valid;
    bf  = tx ? m1f : ld_rob_flag;
    bi  = tx ? m1i : ld_rob_idx;
    bl  = tx ? 2'b00 : 2'b01;
    bt  = tx ? pcf(m1p) + (16'(m1o) << 1) : ld_target;
    chk(tag, "be_valid", 32'(be_valid), 32'(bv));
    if (bv) begin
      chk(tag, "be_age", {be_rob_flag, be_rob_idx}, {bf, bi});
      chk(tag, "be_level", 32'(be_level), 32'(bl));
      chk(tag, "be_target", 32'(be_target), 32'(bt));
    end
    fv = rob_valid || m3v;
    chk(tag, "fe_valid", 32'(fe_valid), 32'(fv));
    if (fv) begin
      chk(tag, "fe_age", {fe_rob_flag, fe_rob_idx}, rob_valid ? {rob_rob_flag, rob_rob_idx} : {m3f, m3i});
      chk(tag, "fe_level", 32'(fe_level), 32'(rob_valid ? rob_level : m3l));
      chk(tag, "fe_target", 32'(fe_target), 32'(rob_valid ? rob_target : m3t));
    end
    chk({tag, " R10"}, "fe_flush_all", 32'(fe_flush_all), 32'(fv && (rob_valid ? rob_level[1] : m3l[1])));
    @(posedge clk);
    #1;
    m1v = sv && !rob_valid; m1f = sf; m1i = si; m1p = sp; m1o = so;
    mlv = bv; mlf = bf; mli = bi;
    m3v = bv; m3f = bf; m3i = bi; m3l = bl; m3t = bt;
    @(negedge clk);
  endtask

  task automatic idle();
    exu_valid = '0; ld_valid = 0; rob_valid = 0;
  endtask

  task automatic set_exu(input int k, input logic f, input logic [3:0] i, input logic [3:0] p, input logic [2:0] o);
    exu_valid[k] = 1; exu_rob_flag[k] = f; exu_rob_idx[k] = i; exu_ftq_ptr[k] = p; exu_ftq_off[k] = o;
  endtask

  task automatic set_ld(input logic f, input logic [3:0] i, input logic [15:0] t);
    ld_valid = 1; ld_rob_flag = f; ld_rob_idx = i; ld_target = t;
  endtask

  initial begin
    #4_100_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int base;
    base = 0;
    repeat (3) @(negedge clk);
    chk("R1", "be_valid in reset", 32'(be_valid), 0);
    chk("R1", "fe_valid in reset", 32'(fe_valid), 0);
    chk("R1", "fe_flush_all in reset", 32'(fe_flush_all), 0);
    rst_n = 1;
    cycle("R1");
    // R2: port 3 wins across the wrap against port 1; R3 one cycle later
    set_exu(1, 1'b1, 4'd2, 4'd5, 3'd1);
    set_exu(3, 1'b0, 4'd14, 4'd9, 3'd3);
    cycle("R2");
    idle(); cycle("R3");
    cycle("R6");
    // R2 tie: lowest port wins
    set_exu(2, 0, 4'd7, 4'd3, 3'd2); set_exu(4, 0, 4'd7, 4'd11, 3'd5);
    cycle("R2 tie"); idle(); cycle("R3"); cycle("R6");
    // R4: load replay alone
    set_ld(1, 4'd4, 16'h1234); cycle("R4"); idle(); cycle("R6");
    // R5: equal age, load replay wins
    set_exu(0, 0, 4'd9, 4'd2, 3'd4); cycle("R5 setup");
    idle(); set_ld(0, 4'd9, 16'h0ABC); cycle("R5 tie"); idle(); cycle("R6");
    // R5: execution older
    set_exu(0, 0, 4'd12, 4'd6, 3'd7); cycle("R5 setup");
    idle(); set_ld(0, 4'd13, 16'h0BBB); cycle("R5 exu older"); idle(); cycle("R6");
    // R7/R8: reorder-buffer redirect with everything else in flight
    set_exu(1, 0, 4'd3, 4'd1, 3'd0); cycle("R8 setup");
    set_exu(2, 0, 4'd4, 4'd8, 3'd6); set_ld(0, 4'd3, 16'h0CCC);
    rob_valid = 1; rob_rob_flag = 0; rob_rob_idx = 4'd1; rob_level = 2'b11; rob_target = 16'h8000;
    cycle("R7");
    idle(); cycle("R8"); cycle("R8");
    rob_valid = 1; rob_level = 2'b00; rob_target = 16'h8100; cycle("R10 conditional");
    rob_level = 2'b10; cycle("R10 flush-after"); idle(); cycle("R8");
    // R9: younger dropped, older kept
    set_ld(1, 4'd5, 16'h0111); cycle("R9 setup");
    set_ld(1, 4'd7, 16'h0222); cycle("R9 younger");
    idle(); cycle("R6");
    set_ld(1, 4'd5, 16'h0333); cycle("R9 setup");
    set_ld(1, 4'd5, 16'h0444); cycle("R9 equal");
    set_ld(1, 4'd3, 16'h0555); cycle("R9 older");
    idle(); cycle("R6");
    // random traffic in a sliding window crossing the wrap point
    for (int n = 0; n < 4000; n++) begin
      int pos;
      base = (base + $urandom_range(0, 2)) % 32;
      for (int k = 0; k < N; k++) begin
        pos = (base + $urandom_range(0, 7)) % 32;
        exu_valid[k] = ($urandom_range(0, 3) == 0);
        exu_rob_flag[k] = pos[4]; exu_rob_idx[k] = pos[3:0];
        exu_ftq_ptr[k] = 4'($urandom); exu_ftq_off[k] = 3'($urandom);
      end
      pos = (base + $urandom_range(0, 7)) % 32;
      ld_valid = ($urandom_range(0, 3) == 0); ld_rob_flag = pos[4]; ld_rob_idx = pos[3:0];
      ld_target = 16'($urandom);
      pos = (base + $urandom_range(0, 7)) % 32;
      rob_valid = ($urandom_range(0, 15) == 0); rob_rob_flag = pos[4]; rob_rob_idx = pos[3:0];
      rob_level = 2'($urandom); rob_target = 16'($urandom);
      cycle("RND");
    end
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule